// File: doc/BRIEF.md
# Staggered Wavefront Vector/Scalar Issue Sequencer

This block models the issue timing of one compute unit. It has four vector SIMD engines, each 16 lanes of 32 bits, and one shared 64-bit scalar ALU. Each SIMD runs its own 64-element wavefront. A vector instruction is accepted once and then executed over four consecutive cycles. Each cycle covers one quarter of the wavefront, so on quarter q, lane i produces element 16q+i. Operands arrive on per-lane buses during the cycle in which their quarter runs. The opcode is held from the accept cycle.

A rotation counter hands the scalar ALU to one SIMD per cycle. In every four-cycle window each SIMD therefore gets one scalar slot. A scalar request is honoured only in its own slot. It comes back from a four-register pipeline four cycles later, tagged with the SIMD that issued it.

The block leaves reset on the second rising clock edge after `rst_n` is released. This edge is called cycle 0. The reset is asserted asynchronously and released through two synchronising flops.

Top module: `wave_issue_cu`

## Requirements
- R1: While reset is active, and until cycle 0, `vr_valid`, `vr_done` and `sc_valid` are low, `sc_slot` is 0 and every `v_ready` bit is high.
- R2: `v_ready[k]` is high exactly when SIMD k is idle or has just sent its quarter-3 beat. A `v_valid[k]` raised while `v_ready[k]` is low is ignored and produces no extra beat.
- R3: An instruction accepted at edge e produces beats at edges e, e+1, e+2 and e+3, observed in the following cycles, with `vr_quarter` 0,1,2,3. Quarter q's lane i result uses the lane-i operands present during quarter q's cycle.
- R4: `vr_done[k]` is high on the quarter-3 beat and on no other beat.
- R5: Opcodes are 0 add, 1 subtract, 2 AND, 3 OR and 4 multiply keeping the low bits. Codes 5 to 7 yield zero. Arithmetic wraps modulo 2^32 for lanes and 2^64 for the scalar ALU.
- R6: A SIMD holding `v_valid` high accepts a new instruction every four cycles, and its beats follow with no gap.
- R7: The four SIMDs run independently and concurrently, with no interaction between their results.
- R8: `sc_slot` counts 0,1,2,3,0,... one step per cycle from cycle 0. `s_valid[k]` is accepted only in a cycle where `sc_slot` equals k. Requests from other SIMDs in that cycle are ignored.
- R9: A scalar request accepted at edge e appears on `sc_result` with `sc_valid` high and `sc_tag` equal to k in the cycle after edge e+3, that is four cycles after issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| v_valid | input | 4 | Per-SIMD vector instruction request |
| v_op | input | 12 | Per-SIMD 3-bit opcode, SIMD k at bits [3k+2:3k] |
| v_a | input | 2048 | Per-SIMD, per-lane first operand, lane i of SIMD k at bits [(16k+i)*32 +: 32] |
| v_b | input | 2048 | Per-SIMD, per-lane second operand, same layout |
| v_ready | output | 4 | SIMD can accept a new instruction this cycle |
| vr_valid | output | 4 | Vector result beat present |
| vr_quarter | output | 8 | Quarter index of the beat, 2 bits per SIMD |
| vr_done | output | 4 | Last-quarter marker |
| vr_data | output | 2048 | Per-lane results, same layout as v_a |
| s_valid | input | 4 | Per-SIMD scalar request |
| s_op | input | 12 | Per-SIMD scalar opcode |
| s_a | input | 256 | Per-SIMD 64-bit scalar first operand |
| s_b | input | 256 | Per-SIMD 64-bit scalar second operand |
| sc_slot | output | 2 | SIMD that owns the scalar slot this cycle |
| sc_valid | output | 1 | Scalar result present |
| sc_tag | output | 2 | SIMD that issued the scalar result |
| sc_result | output | 64 | Scalar result |

## Verification
The hardest situation to reach from the ports is all four SIMDs and the scalar ALU active in the same cycles. In that state each vector engine sits on a different quarter, and requests that arrive while an engine is busy or outside its slot must be dropped. The stimulus holds `v_valid` and `s_valid` high on several SIMDs across many cycles, with opcodes that change every cycle. A reference model in the bench tracks each SIMD's quarter and the slot rotation, so every dropped request shows up as an unexpected beat. Fixed operand modes drive the wraparound corners: all-ones plus one, zero minus one, and a multiply whose product overflows the low bits.

// File: rtl/wave_pkg.sv
package wave_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_MUL = 3'd4
  } op_e;
endpackage

// File: rtl/wave_alu.sv
module wave_alu
  import wave_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_MUL:  y = a * b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/wave_vec_simd.sv
module wave_vec_simd
  import wave_pkg::*;
#(
  parameter  int LANES    = 16,
  parameter  int LANE_W   = 32,
  parameter  int QUARTERS = 4,
  localparam int QW       = $clog2(QUARTERS),
  localparam int DW       = LANES * LANE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] in_op,
  input  logic [DW-1:0]  in_a,
  input  logic [DW-1:0]  in_b,
  output logic           ready,
  output logic           out_valid,
  output logic [QW-1:0]  out_quarter,
  output logic           out_done,
  output logic [DW-1:0]  out_data
);
  localparam logic [QW-1:0] QLAST = QW'(QUARTERS - 1);

  logic [QW-1:0]  q_r, q_nxt;
  logic [OPW-1:0] op_r, cur_op;
  logic           accept, run;
  logic [DW-1:0]  lane_y;

  // next-state
  always_comb begin
    accept = in_valid && (q_r == '0);
    run    = accept || (q_r != '0);
    cur_op = accept ? in_op : op_r;
    q_nxt  = q_r;
    if (run) begin
      q_nxt = (q_r == QLAST) ? '0 : q_r + 1'b1;
    end
  end

  assign ready = (q_r == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    wave_alu #(.W(LANE_W)) u_alu (
      .op (cur_op),
      .a  (in_a[i*LANE_W +: LANE_W]),
      .b  (in_b[i*LANE_W +: LANE_W]),
      .y  (lane_y[i*LANE_W +: LANE_W])
    );
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r         <= '0;
      op_r        <= '0;
      out_valid   <= 1'b0;
      out_quarter <= '0;
      out_done    <= 1'b0;
    end else begin
      q_r       <= q_nxt;
      out_valid <= run;
      out_done  <= run && (q_r == QLAST);
      if (accept) op_r <= in_op;
      if (run) out_quarter <= q_r;
    end
  end

  // datapath register, enabled only on a running quarter
  always_ff @(posedge clk) begin
    if (run) out_data <= lane_y;
  end
endmodule

// File: rtl/wave_scalar_pipe.sv
module wave_scalar_pipe
  import wave_pkg::*;
#(
  parameter  int N_SIMD = 4,
  parameter  int SC_W   = 64,
  parameter  int DEPTH  = 4,
  localparam int SW     = $clog2(N_SIMD)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SIMD-1:0]     s_valid,
  input  logic [N_SIMD*OPW-1:0] s_op,
  input  logic [N_SIMD*SC_W-1:0] s_a,
  input  logic [N_SIMD*SC_W-1:0] s_b,
  output logic [SW-1:0]         slot,
  output logic                  out_valid,
  output logic [SW-1:0]         out_tag,
  output logic [SC_W-1:0]       out_data
);
  localparam logic [SW-1:0] SLAST = SW'(N_SIMD - 1);

  logic [SW-1:0]   slot_r, slot_nxt;
  logic            take;
  logic [OPW-1:0]  sel_op;
  logic [SC_W-1:0] sel_a, sel_b, y;
  logic            pv [DEPTH];
  logic [SW-1:0]   pt [DEPTH];
  logic [SC_W-1:0] pd [DEPTH];

  always_comb begin
    take     = s_valid[slot_r];
    sel_op   = s_op[slot_r*OPW +: OPW];
    sel_a    = s_a[slot_r*SC_W +: SC_W];
    sel_b    = s_b[slot_r*SC_W +: SC_W];
    slot_nxt = (slot_r == SLAST) ? '0 : slot_r + 1'b1;
  end

  wave_alu #(.W(SC_W)) u_alu (
    .op (sel_op),
    .a  (sel_a),
    .b  (sel_b),
    .y  (y)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_r <= '0;
      for (int i = 0; i < DEPTH; i++) pv[i] <= 1'b0;
    end else begin
      slot_r <= slot_nxt;
      pv[0]  <= take;
      for (int i = 1; i < DEPTH; i++) pv[i] <= pv[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      pt[0] <= slot_r;
      pd[0] <= y;
    end
    for (int i = 1; i < DEPTH; i++) begin
      if (pv[i-1]) begin
        pt[i] <= pt[i-1];
        pd[i] <= pd[i-1];
      end
    end
  end

  assign slot      = slot_r;
  assign out_valid = pv[DEPTH-1];
  assign out_tag   = pt[DEPTH-1];
  assign out_data  = pd[DEPTH-1];
endmodule

// File: rtl/wave_issue_cu.sv
module wave_issue_cu
  import wave_pkg::*;
#(
  parameter  int N_SIMD   = 4,
  parameter  int LANES    = 16,
  parameter  int LANE_W   = 32,
  parameter  int QUARTERS = 4,
  parameter  int SC_W     = 64,
  parameter  int SC_DEPTH = 4,
  localparam int QW       = $clog2(QUARTERS),
  localparam int SW       = $clog2(N_SIMD),
  localparam int DW       = LANES * LANE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SIMD-1:0]      v_valid,
  input  logic [N_SIMD*OPW-1:0]  v_op,
  input  logic [N_SIMD*DW-1:0]   v_a,
  input  logic [N_SIMD*DW-1:0]   v_b,
  output logic [N_SIMD-1:0]      v_ready,
  output logic [N_SIMD-1:0]      vr_valid,
  output logic [N_SIMD*QW-1:0]   vr_quarter,
  output logic [N_SIMD-1:0]      vr_done,
  output logic [N_SIMD*DW-1:0]   vr_data,
  input  logic [N_SIMD-1:0]      s_valid,
  input  logic [N_SIMD*OPW-1:0]  s_op,
  input  logic [N_SIMD*SC_W-1:0] s_a,
  input  logic [N_SIMD*SC_W-1:0] s_b,
  output logic [SW-1:0]          sc_slot,
  output logic                   sc_valid,
  output logic [SW-1:0]          sc_tag,
  output logic [SC_W-1:0]        sc_result
);
  logic rst_meta_n, rst_q_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  for (genvar k = 0; k < N_SIMD; k++) begin : g_simd
    wave_vec_simd #(
      .LANES    (LANES),
      .LANE_W   (LANE_W),
      .QUARTERS (QUARTERS)
    ) u_simd (
      .clk         (clk),
      .rst_n       (rst_q_n),
      .in_valid    (v_valid[k]),
      .in_op       (v_op[k*OPW +: OPW]),
      .in_a        (v_a[k*DW +: DW]),
      .in_b        (v_b[k*DW +: DW]),
      .ready       (v_ready[k]),
      .out_valid   (vr_valid[k]),
      .out_quarter (vr_quarter[k*QW +: QW]),
      .out_done    (vr_done[k]),
      .out_data    (vr_data[k*DW +: DW])
    );
  end

  wave_scalar_pipe #(
    .N_SIMD (N_SIMD),
    .SC_W   (SC_W),
    .DEPTH  (SC_DEPTH)
  ) u_scalar (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .s_valid   (s_valid),
    .s_op      (s_op),
    .s_a       (s_a),
    .s_b       (s_b),
    .slot      (sc_slot),
    .out_valid (sc_valid),
    .out_tag   (sc_tag),
    .out_data  (sc_result)
  );
endmodule

// File: rtl/wave_issue_cu_chk.sv
module wave_issue_cu_chk #(
  parameter  int N_SIMD   = 4,
  parameter  int QUARTERS = 4,
  parameter  int SC_DEPTH = 4,
  localparam int QW       = $clog2(QUARTERS),
  localparam int SW       = $clog2(N_SIMD)
) (
  input logic                 clk,
  input logic                 rst_q_n,
  input logic [N_SIMD-1:0]    v_valid,
  input logic [N_SIMD-1:0]    v_ready,
  input logic [N_SIMD-1:0]    vr_valid,
  input logic [N_SIMD*QW-1:0] vr_quarter,
  input logic [N_SIMD-1:0]    vr_done,
  input logic [SW-1:0]        sc_slot,
  input logic                 sc_valid,
  input logic [SW-1:0]        sc_tag
);
  localparam logic [QW-1:0] QLAST = QW'(QUARTERS - 1);
  localparam logic [SW-1:0] SLAST = SW'(N_SIMD - 1);

  logic          started;
  logic [SW-1:0] slot_hist [SC_DEPTH];

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      started <= 1'b0;
      for (int i = 0; i < SC_DEPTH; i++) slot_hist[i] <= '0;
    end else begin
      started      <= 1'b1;
      slot_hist[0] <= sc_slot;
      for (int i = 1; i < SC_DEPTH; i++) slot_hist[i] <= slot_hist[i-1];
    end
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_q_n |-> (vr_valid == '0 && vr_done == '0 && !sc_valid && sc_slot == '0));

  for (genvar k = 0; k < N_SIMD; k++) begin : g_chk
    // R3
    a_r3_quarter_step: assert property (@(posedge clk) disable iff (!rst_q_n)
      (vr_valid[k] && vr_quarter[k*QW +: QW] != QLAST)
      |=> (vr_valid[k] && vr_quarter[k*QW +: QW] == $past(vr_quarter[k*QW +: QW]) + 1'b1));
    // R3
    a_r3_first_beat_issued: assert property (@(posedge clk) disable iff (!rst_q_n)
      (vr_valid[k] && vr_quarter[k*QW +: QW] == '0) |-> $past(v_valid[k] && v_ready[k]));
    // R2
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_q_n)
      (vr_valid[k] && vr_quarter[k*QW +: QW] != QLAST) |-> !v_ready[k]);
    // R4
    a_r4_done_only_last: assert property (@(posedge clk) disable iff (!rst_q_n)
      vr_done[k] |-> (vr_valid[k] && vr_quarter[k*QW +: QW] == QLAST));
    // R4
    a_r4_last_has_done: assert property (@(posedge clk) disable iff (!rst_q_n)
      (vr_valid[k] && vr_quarter[k*QW +: QW] == QLAST) |-> vr_done[k]);
  end

  // R8
  a_r8_slot_rotates: assert property (@(posedge clk) disable iff (!rst_q_n)
    started |-> (sc_slot == (($past(sc_slot) == SLAST) ? '0 : $past(sc_slot) + 1'b1)));

  // R9
  a_r9_tag_matches_slot: assert property (@(posedge clk) disable iff (!rst_q_n)
    sc_valid |-> (sc_tag == slot_hist[SC_DEPTH-1]));
endmodule

bind wave_issue_cu wave_issue_cu_chk #(
  .N_SIMD   (N_SIMD),
  .QUARTERS (QUARTERS),
  .SC_DEPTH (SC_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .v_valid    (v_valid),
  .v_ready    (v_ready),
  .vr_valid   (vr_valid),
  .vr_quarter (vr_quarter),
  .vr_done    (vr_done),
  .sc_slot    (sc_slot),
  .sc_valid   (sc_valid),
  .sc_tag     (sc_tag)
);

// File: tb/tb_wave_issue_cu.sv
module tb_wave_issue_cu;
  localparam int N  = 4;
  localparam int L  = 16;
  localparam int W  = 32;
  localparam int DW = L * W;
  localparam int SCW = 64;

  typedef struct {
    int              due;
    int              q;
    bit              done;
    logic [DW-1:0]   data;
    string           tag;
  } vexp_t;

  typedef struct {
    int              due;
    int              tag;
    logic [SCW-1:0]  data;
  } sexp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]     v_valid = '0;
  logic [N*3-1:0]   v_op = '0;
  logic [N*DW-1:0]  v_a = '0;
  logic [N*DW-1:0]  v_b = '0;
  logic [N-1:0]     v_ready;
  logic [N-1:0]     vr_valid;
  logic [N*2-1:0]   vr_quarter;
  logic [N-1:0]     vr_done;
  logic [N*DW-1:0]  vr_data;
  logic [N-1:0]     s_valid = '0;
  logic [N*3-1:0]   s_op = '0;
  logic [N*SCW-1:0] s_a = '0;
  logic [N*SCW-1:0] s_b = '0;
  logic [1:0]       sc_slot;
  logic             sc_valid;
  logic [1:0]       sc_tag;
  logic [SCW-1:0]   sc_result;

  wave_issue_cu dut (
    .clk(clk), .rst_n(rst_n),
    .v_valid(v_valid), .v_op(v_op), .v_a(v_a), .v_b(v_b), .v_ready(v_ready),
    .vr_valid(vr_valid), .vr_quarter(vr_quarter), .vr_done(vr_done), .vr_data(vr_data),
    .s_valid(s_valid), .s_op(s_op), .s_a(s_a), .s_b(s_b),
    .sc_slot(sc_slot), .sc_valid(sc_valid), .sc_tag(sc_tag), .sc_result(sc_result)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  vexp_t vq [N][$];
  sexp_t sq [$];

  // bench model state
  int          mq [N];
  logic [2:0]  mop [N];
  logic [N-1:0] req_v = '0;
  logic [N-1:0] req_s = '0;
  logic [2:0]  req_op [N];
  logic [2:0]  req_sop [N];
  int          mode = 0;
  string       cur_tag = "R3";

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [63:0] ref_op(logic [2:0] op, logic [63:0] a, logic [63:0] b, int w);
    logic [63:0] r;
    case (op)
      3'd0: r = a + b;
      3'd1: r = a - b;
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a * b;
      default: r = 64'd0;
    endcase
    if (w == 32) r = {32'd0, r[31:0]};
    return r;
  endfunction

  function automatic logic [31:0] gen(int md, int k, int e, int lane, int s);
    logic [31:0] h;
    case (md)
      1: h = s ? 32'h0000_0001 : 32'hFFFF_FFFF;
      2: h = s ? 32'h0000_0001 : 32'h0000_0000;
      3: h = s ? 32'h0000_0002 : 32'h8000_0000;
      default: begin
        h = 32'(e) * 32'h9E37_79B1;
        h = h ^ (32'(k) * 32'h3C6E_F372) ^ (32'(lane) * 32'h0100_0193);
        if (s != 0) h = h ^ 32'hDEAD_BEEF;
        h = h + 32'(lane);
      end
    endcase
    return h;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp_v, cyc);
    end
  endtask

  // driver: one cycle of stimulus, model update and expectation push
  task automatic step();
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < L; i++) begin
        v_a[(k*L+i)*W +: W] = gen(mode, k, cyc, i, 0);
        v_b[(k*L+i)*W +: W] = gen(mode, k, cyc, i, 1);
      end
      s_a[k*SCW +: SCW] = {gen(mode, k, cyc, 40, 0), gen(mode, k, cyc, 41, 0)};
      s_b[k*SCW +: SCW] = {gen(mode, k, cyc, 42, 1), gen(mode, k, cyc, 43, 1)};
      v_op[k*3 +: 3] = req_op[k];
      s_op[k*3 +: 3] = req_sop[k];
    end
    v_valid = req_v;
    s_valid = req_s;
    for (int k = 0; k < N; k++) begin
      vexp_t it;
      bit acc;
      // R2: readiness follows the bench's own quarter model
      chk(v_ready[k] == (mq[k] == 0), "R2 ready", 64'(v_ready[k]), 64'(mq[k] == 0));
      acc = (cyc >= 2) && req_v[k] && (mq[k] == 0);
      if (acc) mop[k] = req_op[k];
      if (acc || mq[k] != 0) begin
        it.due  = cyc + 1;
        it.q    = mq[k];
        it.done = (mq[k] == 3);
        it.tag  = cur_tag;
        for (int i = 0; i < L; i++) begin
          logic [63:0] r;
          r = ref_op(mop[k], {32'd0, gen(mode, k, cyc, i, 0)}, {32'd0, gen(mode, k, cyc, i, 1)}, 32);
          it.data[i*W +: W] = r[31:0];
        end
        vq[k].push_back(it);
        mq[k] = (mq[k] + 1) % 4;
      end
    end
    if (cyc >= 2) begin
      int sl;
      sl = (cyc - 2) % 4;
      if (req_s[sl]) begin
        sexp_t se;
        se.due  = cyc + 4;
        se.tag  = sl;
        se.data = ref_op(req_sop[sl], s_a[sl*SCW +: SCW], s_b[sl*SCW +: SCW], 64);
        sq.push_back(se);
      end
      // R8: rotation counter follows cycles since release
      chk(sc_slot == 2'(sl), "R8 slot", 64'(sc_slot), 64'(sl));
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_v = '0;
    req_s = '0;
    for (int j = 0; j < n; j++) step();
  endtask

  // monitor: compares results against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int k = 0; k < N; k++) begin
        if (vr_valid[k]) begin
          if (vq[k].size() == 0) begin
            chk(1'b0, "R2 unexpected vector beat", 64'(k), 64'hFFFF);
          end else begin
            vexp_t e;
            e = vq[k].pop_front();
            chk(cyc == e.due, "R3 beat timing", 64'(cyc), 64'(e.due));
            chk(vr_quarter[k*2 +: 2] == 2'(e.q), "R3 quarter", 64'(vr_quarter[k*2 +: 2]), 64'(e.q));
            chk(vr_done[k] == e.done, "R4 done", 64'(vr_done[k]), 64'(e.done));
            checks++;
            if (vr_data[k*DW +: DW] !== e.data) begin
              errors++;
              $display("FAIL %s data simd%0d q%0d: actual %h expected %h", e.tag, k, e.q,
                       vr_data[k*DW +: DW], e.data);
            end
          end
        end
      end
      if (sc_valid) begin
        if (sq.size() == 0) begin
          chk(1'b0, "R8 unexpected scalar result", 64'(sc_tag), 64'hFFFF);
        end else begin
          sexp_t e;
          e = sq.pop_front();
          chk(cyc == e.due, "R9 scalar timing", 64'(cyc), 64'(e.due));
          chk(sc_tag == 2'(e.tag), "R9 scalar tag", 64'(sc_tag), 64'(e.tag));
          chk(sc_result == e.data, "R9 scalar result", sc_result, e.data);
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      mq[k] = 0; mop[k] = '0; req_op[k] = '0; req_sop[k] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(vr_valid == '0, "R1 vr_valid in reset", 64'(vr_valid), 0);
    chk(!sc_valid, "R1 sc_valid in reset", 64'(sc_valid), 0);
    chk(sc_slot == 0, "R1 slot in reset", 64'(sc_slot), 0);
    chk(v_ready == '1, "R1 ready in reset", 64'(v_ready), 64'hF);
    rst_n = 1'b1;
    idle(1);
    chk(vr_valid == '0 && !sc_valid && sc_slot == 0, "R1 quiet before cycle 0",
        {vr_valid, sc_valid, sc_slot}, 0);
    idle(1);

    // R3 R5: single add on SIMD0
    cur_tag = "R3 R5 add";
    req_op[0] = 3'd0; req_v = 4'b0001; step();
    idle(5);

    // R7 R5: all four SIMDs together, every opcode incl. reserved codes
    cur_tag = "R7 R5 ops 0-3";
    for (int k = 0; k < N; k++) req_op[k] = 3'(k);
    req_v = '1; step();
    idle(3);
    cur_tag = "R7 R5 ops 4-7";
    for (int k = 0; k < N; k++) req_op[k] = 3'(k + 4);
    req_v = '1; step();
    idle(5);

    // R5: wraparound corners
    for (int md = 1; md <= 3; md++) begin
      mode = md;
      cur_tag = "R5 corner";
      req_op[0] = 3'd0; req_op[1] = 3'd1; req_op[2] = 3'd4; req_op[3] = 3'd3;
      req_v = '1; step();
      idle(4);
    end
    mode = 0;

    // R2 R6: SIMD1 holds valid with changing opcode; SIMD2 requests while busy
    cur_tag = "R6 back-to-back";
    for (int j = 0; j < 12; j++) begin
      req_op[1] = 3'(j % 5);
      req_op[2] = (j == 0) ? 3'd4 : 3'd3;
      req_v = (j < 4) ? 4'b0110 : 4'b0010;
      step();
    end
    idle(5);

    // R8 R9: every SIMD requests the scalar ALU each cycle
    cur_tag = "R9";
    for (int j = 0; j < 8; j++) begin
      for (int k = 0; k < N; k++) req_sop[k] = 3'((j + k) % 6);
      req_s = '1; req_v = '0; step();
    end
    idle(6);
    // R8: request only off-slot, must be ignored
    req_s = 4'(1 << ((cyc - 2 + 1) % 4)); req_v = '0; step();
    idle(6);
    mode = 1;
    req_sop[0] = 3'd0; req_sop[1] = 3'd4; req_sop[2] = 3'd1; req_sop[3] = 3'd3;
    for (int j = 0; j < 4; j++) begin
      req_s = '1; req_v = '0; step();
    end
    mode = 0;
    idle(6);

    // R7: mixed concurrent traffic
    cur_tag = "R7 mixed";
    for (int j = 0; j < 40; j++) begin
      for (int k = 0; k < N; k++) begin
        req_v[k]  = ((cyc * 7 + k * 3) % 5) != 0;
        req_op[k] = 3'((cyc + k) % 8);
        req_s[k]  = ((cyc + k) % 3) != 0;
        req_sop[k] = 3'((cyc * 3 + k) % 7);
      end
      step();
    end
    idle(10);

    for (int k = 0; k < N; k++)
      chk(vq[k].size() == 0, "R3 all beats delivered", 64'(vq[k].size()), 0);
    chk(sq.size() == 0, "R9 all scalar results delivered", 64'(sq.size()), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule